// File: doc/BRIEF.md
# Operand Read Sequencer for a Function Unit

This block sits between an instruction issue stage and an arithmetic unit. When an operation is issued, it stores the operation code and raises one read request for each source operand. It then waits for the register side to grant those requests. Each grant delivers one operand value, which is captured into a holding register that feeds the arithmetic unit. When every request has been granted, the block signals a one-cycle start to the arithmetic unit and returns to idle.

A cancel input aborts the operation at any point. It drops every outstanding request, clears the captured operands and returns the unit to idle. A small combinational arithmetic stand-in computes a result from the captured operands, so the block can be used on its own.

Top module: `opnd_seq_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_o`, `opnd_o`, `alu_start_o` and `alu_res_o` are all zero.
- R2: No bit of `req_o` is high in any cycle before the first clock edge, after reset, at which `issue_i` is sampled high.
- R3: When `issue_i` is sampled high while the unit is idle (no request pending and `alu_start_o` low) and `cancel_i` is low, every bit of `req_o` is high in the next cycle.
- R4: A bit of `req_o` that is high falls only after an edge at which its own `grant_i` bit or `cancel_i` was sampled high.
- R5: After an edge at which `grant_i[i]` was high while any request was pending, `req_o[i]` is low. The other request bits keep their values unless they were granted too.
- R6: Operand i occupies bits `[16*i+15:16*i]` of `opnd_i` and `opnd_o`. A grant on a pending bit i loads that slice into `opnd_o` in the next cycle. A grant on a bit that is not pending leaves `opnd_o` unchanged. Issue clears all operand slices to zero.
- R7: A cancel sampled while any request is pending leaves `req_o` and `opnd_o` all zero in the next cycle, and `alu_start_o` stays low.
- R8: `alu_start_o` is high for exactly one cycle. That cycle immediately follows the edge at which the last pending request was granted without a cancel, and `req_o` is zero in it.
- R9: `alu_res_o` is a function of the latched op code and the captured operands a = slice 0 and b = slice 1. Op 0 gives a+b, op 1 gives a-b, op 2 gives a AND b, op 3 gives a XOR b, all modulo 2^16.
- R10: An issue and a cancel sampled at the same edge raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe for a new operation |
| op_i | input | 2 | Operation code captured at issue |
| grant_i | input | 2 | Per-operand read grant |
| cancel_i | input | 1 | Abort the current operation |
| opnd_i | input | 32 | Operand values offered with the grants, one 16-bit slice per operand |
| req_o | output | 2 | Per-operand read request |
| opnd_o | output | 32 | Captured operands held for the arithmetic unit |
| alu_start_o | output | 1 | One-cycle start to the arithmetic unit |
| alu_res_o | output | 16 | Stand-in arithmetic result |

## Verification
The assertions rely on one rule about the environment: `issue_i` is never raised while a request is pending, or in the cycle right after one was pending. They also rely on reset being held in the first cycles. The random stimulus enforces this rule. It raises issue only when the reference model shows no pending request in the current cycle and none in the previous one. It also holds reset for several edges before any traffic starts. Grants and cancels are otherwise unconstrained, including grants to operands that are not pending and cancels that land in the same cycle as issue, as a grant, or as the start pulse.

// File: rtl/opseq_pkg.sv
`timescale 1ns/1ps
package opseq_pkg;

   // Phases of one operation
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_READ = 2'd1,
      SEQ_EXEC = 2'd2
   } seq_state_t;

   // Operation codes decoded by the arithmetic stand-in
   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_AND = 2'd2,
      ALU_XOR = 2'd3
   } alu_op_t;

endpackage

// File: rtl/opseq_ctrl.sv
`timescale 1ns/1ps
module opseq_ctrl
   import opseq_pkg::*;
#(
   parameter int NUM_RD = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_i,
   input  logic              cancel_i,
   input  logic [NUM_RD-1:0] grant_i,
   output logic [NUM_RD-1:0] req_o,
   output logic [NUM_RD-1:0] cap_o,
   output logic              clr_o,
   output logic              load_o,
   output logic              exec_o
);

   seq_state_t        state_q, state_d;
   logic [NUM_RD-1:0] req_q, req_d;
   logic              accept;
   logic              reading;

   always_comb begin
      reading = (state_q == SEQ_READ);
      accept  = (state_q == SEQ_IDLE) & issue_i & ~cancel_i;
   end

   // Per-port capture: a grant counts only on a pending bit, never under cancel
   for (genvar i = 0; i < NUM_RD; i++) begin : g_port
      always_comb begin
         cap_o[i] = reading & req_q[i] & grant_i[i] & ~cancel_i;
         if (cancel_i) begin
            req_d[i] = 1'b0;
         end else if (accept) begin
            req_d[i] = 1'b1;
         end else begin
            req_d[i] = req_q[i] & ~cap_o[i];
         end
      end
   end

   always_comb begin
      state_d = state_q;
      if (cancel_i) begin
         state_d = SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (accept)         state_d = SEQ_READ;
            SEQ_READ: if (req_d == '0)    state_d = SEQ_EXEC;
            SEQ_EXEC:                     state_d = SEQ_IDLE;
            default:                      state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         req_q   <= '0;
      end else begin
         state_q <= state_d;
         req_q   <= req_d;
      end
   end

   always_comb begin
      req_o  = req_q;
      clr_o  = cancel_i | accept;
      load_o = accept;
      exec_o = (state_q == SEQ_EXEC);
   end

endmodule

// File: rtl/opseq_opnd_bank.sv
`timescale 1ns/1ps
module opseq_opnd_bank #(
   parameter int DATA_W = 16,
   parameter int NUM_RD = 2,
   localparam int BUS_W = DATA_W * NUM_RD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic [NUM_RD-1:0] cap_i,
   input  logic [BUS_W-1:0]  data_i,
   output logic [BUS_W-1:0]  opnd_o
);

   for (genvar i = 0; i < NUM_RD; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;

      always_ff @(posedge clk) begin
         if (rst || clr_i) begin
            slot_q <= '0;
         end else if (cap_i[i]) begin
            slot_q <= data_i[i*DATA_W +: DATA_W];
         end
      end

      assign opnd_o[i*DATA_W +: DATA_W] = slot_q;
   end

endmodule

// File: rtl/opseq_alu.sv
`timescale 1ns/1ps
module opseq_alu
   import opseq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);

   alu_op_t op;

   always_comb begin
      op = alu_op_t'(op_i);
      unique case (op)
         ALU_ADD: res_o = a_i + b_i;
         ALU_SUB: res_o = a_i - b_i;
         ALU_AND: res_o = a_i & b_i;
         ALU_XOR: res_o = a_i ^ b_i;
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/opnd_seq_unit.sv
`timescale 1ns/1ps
module opnd_seq_unit #(
   parameter int DATA_W = 16,
   parameter int NUM_RD = 2,
   parameter int OP_W   = 2,
   localparam int BUS_W = DATA_W * NUM_RD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [NUM_RD-1:0] grant_i,
   input  logic              cancel_i,
   input  logic [BUS_W-1:0]  opnd_i,
   output logic [NUM_RD-1:0] req_o,
   output logic [BUS_W-1:0]  opnd_o,
   output logic              alu_start_o,
   output logic [DATA_W-1:0] alu_res_o
);

   // Elaboration-time parameter checks
   if (NUM_RD < 2) begin : g_bad_ports
      $error("opnd_seq_unit: NUM_RD must be at least 2");
   end
   if (OP_W != 2) begin : g_bad_op
      $error("opnd_seq_unit: OP_W must be 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("opnd_seq_unit: DATA_W must be positive");
   end

   logic [NUM_RD-1:0] cap;
   logic              clr;
   logic              load;
   logic [OP_W-1:0]   op_q;

   opseq_ctrl #(.NUM_RD(NUM_RD)) i_ctrl (
      .clk      (clk),
      .rst      (rst),
      .issue_i  (issue_i),
      .cancel_i (cancel_i),
      .grant_i  (grant_i),
      .req_o    (req_o),
      .cap_o    (cap),
      .clr_o    (clr),
      .load_o   (load),
      .exec_o   (alu_start_o)
   );

   opseq_opnd_bank #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) i_bank (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr),
      .cap_i  (cap),
      .data_i (opnd_i),
      .opnd_o (opnd_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q <= '0;
      end else if (load) begin
         op_q <= op_i;
      end
   end

   opseq_alu #(.DATA_W(DATA_W)) i_alu (
      .op_i  (op_q[1:0]),
      .a_i   (opnd_o[0 +: DATA_W]),
      .b_i   (opnd_o[DATA_W +: DATA_W]),
      .res_o (alu_res_o)
   );

endmodule

// File: rtl/opnd_seq_chk.sv
`timescale 1ns/1ps
module opnd_seq_chk #(
   parameter int DATA_W = 16,
   parameter int NUM_RD = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     issue_i,
   input logic [NUM_RD-1:0]        grant_i,
   input logic                     cancel_i,
   input logic [NUM_RD-1:0]        req_o,
   input logic [DATA_W*NUM_RD-1:0] opnd_o,
   input logic                     alu_start_o
);

   logic started_q;
   logic past_ok_q;
   logic seen_issue_q;

   always_ff @(posedge clk) begin
      started_q <= 1'b1;
      past_ok_q <= ~rst;
      if (rst) begin
         seen_issue_q <= 1'b0;
      end else if (issue_i) begin
         seen_issue_q <= 1'b1;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      (started_q && $past(rst)) |-> (req_o == '0 && opnd_o == '0 && !alu_start_o)); // R1

   AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (rst)
      !seen_issue_q |-> (req_o == '0)); // R2

   AST_ISSUE_RAISES: assert property (@(posedge clk) disable iff (rst)
      (issue_i && !cancel_i && req_o == '0 && !alu_start_o) |=> (req_o == '1)); // R3

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      past_ok_q |-> (($past(req_o) & ~req_o & ~$past(grant_i) & ~{NUM_RD{$past(cancel_i)}}) == '0)); // R4

   AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (rst)
      (past_ok_q && $past(req_o) != '0) |-> ((req_o & $past(grant_i)) == '0)); // R5

   AST_CANCEL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (past_ok_q && $past(req_o) != '0 && $past(cancel_i)) |-> (req_o == '0 && opnd_o == '0 && !alu_start_o)); // R7

   AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
      alu_start_o |=> !alu_start_o); // R8

   AST_START_NO_REQ: assert property (@(posedge clk) disable iff (rst)
      alu_start_o |-> (req_o == '0)); // R8

   AST_ISSUE_CANCEL: assert property (@(posedge clk) disable iff (rst)
      (issue_i && cancel_i) |=> (req_o == '0)); // R10

endmodule

bind opnd_seq_unit opnd_seq_chk #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) i_chk (
   .clk         (clk),
   .rst         (rst),
   .issue_i     (issue_i),
   .grant_i     (grant_i),
   .cancel_i    (cancel_i),
   .req_o       (req_o),
   .opnd_o      (opnd_o),
   .alu_start_o (alu_start_o)
);

// File: tb/test_opnd_seq_unit.sv
`timescale 1ns/1ps
module test_opnd_seq_unit;

   localparam int DW = 16;
   localparam int NR = 2;
   localparam int OW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          issue = 1'b0;
   logic [OW-1:0] op = '0;
   logic [NR-1:0] grant = '0;
   logic          cancel = 1'b0;
   logic [NR*DW-1:0] din = '0;
   logic [NR-1:0] req;
   logic [NR*DW-1:0] opnd;
   logic          start;
   logic [DW-1:0] res;

   always #2.5 clk = ~clk;

   opnd_seq_unit #(.DATA_W(DW), .NUM_RD(NR), .OP_W(OW)) i_opnd_seq_unit (
      .clk         (clk),
      .rst         (rst),
      .issue_i     (issue),
      .op_i        (op),
      .grant_i     (grant),
      .cancel_i    (cancel),
      .opnd_i      (din),
      .req_o       (req),
      .opnd_o      (opnd),
      .alu_start_o (start),
      .alu_res_o   (res)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Reference model state, built from the requirements
   logic [NR-1:0] m_req = '0;
   logic [NR-1:0] m_req_prev = '0;
   logic [DW-1:0] m_a = '0;
   logic [DW-1:0] m_b = '0;
   logic [OW-1:0] m_op = '0;
   int            m_st = 0;   // 0 idle, 1 reading, 2 start cycle

   function automatic logic [DW-1:0] alu_ref(logic [OW-1:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
      case (o)
         2'd0:    return a + b;
         2'd1:    return a - b;
         2'd2:    return a & b;
         default: return a ^ b;
      endcase
   endfunction

   task automatic chk(string tag, longint unsigned act, longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_edge(logic iss, logic [OW-1:0] o, logic [NR-1:0] g, logic c,
                             logic [DW-1:0] d0, logic [DW-1:0] d1);
      m_req_prev = m_req;
      if (c) begin
         m_req = '0; m_a = '0; m_b = '0; m_st = 0;
      end else if (m_st == 0) begin
         if (iss) begin
            m_req = '1; m_a = '0; m_b = '0; m_op = o; m_st = 1;
         end
      end else if (m_st == 1) begin
         if (g[0] && m_req[0]) begin m_a = d0; m_req[0] = 1'b0; end
         if (g[1] && m_req[1]) begin m_b = d1; m_req[1] = 1'b0; end
         if (m_req == '0) m_st = 2;
      end else begin
         m_st = 0;
      end
   endtask

   task automatic cmp_all();
      chk("R4 request vector", req, m_req);
      chk("R6 operands", opnd, {m_b, m_a});
      chk("R8 start", start, (m_st == 2));
      chk("R9 result", res, alu_ref(m_op, m_a, m_b));
   endtask

   task automatic step(logic iss, logic [OW-1:0] o, logic [NR-1:0] g, logic c,
                       logic [DW-1:0] d0, logic [DW-1:0] d1);
      issue = iss; op = o; grant = g; cancel = c; din = {d1, d0};
      @(posedge clk);
      model_edge(iss, o, g, c, d0, d1);
      @(negedge clk);
      cmp_all();
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 request after reset", req, 0);
      chk("R1 operands after reset", opnd, 0);
      chk("R1 start after reset", start, 0);
      chk("R1 result after reset", res, 0);

      // R2: grants and cancels with no issue yet
      for (int k = 0; k < 12; k++) begin
         step(1'b0, 2'd0, NR'($urandom_range(3)), 1'($urandom_range(1)), 16'($urandom), 16'($urandom));
         chk("R2 no request before issue", req, 0);
      end

      // R3: issue raises both requests
      step(1'b1, 2'd1, 2'b00, 1'b0, 16'h0, 16'h0);
      chk("R3 requests after issue", req, 2'b11);

      // R5 and R6: grant operand 0 only
      step(1'b0, 2'd0, 2'b01, 1'b0, 16'h1234, 16'hffff);
      chk("R5 only granted bit drops", req, 2'b10);
      chk("R6 operand 0 captured", opnd, {16'h0000, 16'h1234});

      // R6: grant on a bit that is no longer pending is ignored
      step(1'b0, 2'd0, 2'b01, 1'b0, 16'hdead, 16'h0);
      chk("R6 stale grant ignored", opnd, {16'h0000, 16'h1234});
      chk("R4 pending bit held", req, 2'b10);

      // R8 and R9: last grant starts the ALU
      step(1'b0, 2'd0, 2'b10, 1'b0, 16'h0, 16'h0034);
      chk("R8 start after last grant", start, 1);
      chk("R9 subtract result", res, 16'h1200);
      step(1'b0, 2'd0, 2'b00, 1'b0, 16'h0, 16'h0);
      chk("R8 start lasts one cycle", start, 0);

      // R7: cancel in the middle of the read phase
      step(1'b1, 2'd0, 2'b00, 1'b0, 16'h0, 16'h0);
      step(1'b0, 2'd0, 2'b01, 1'b0, 16'h0005, 16'h0);
      step(1'b0, 2'd0, 2'b10, 1'b1, 16'h0, 16'h0077);
      chk("R7 cancel clears requests", req, 0);
      chk("R7 cancel clears operands", opnd, 0);
      step(1'b0, 2'd0, 2'b00, 1'b0, 16'h0, 16'h0);
      chk("R7 no start after cancel", start, 0);

      // R10: issue and cancel together
      step(1'b1, 2'd2, 2'b00, 1'b1, 16'h0, 16'h0);
      chk("R10 issue with cancel", req, 0);

      // Both grants in one cycle
      step(1'b1, 2'd3, 2'b00, 1'b0, 16'h0, 16'h0);
      step(1'b0, 2'd0, 2'b11, 1'b0, 16'hf0f0, 16'h0ff0);
      chk("R5 both bits drop", req, 0);
      chk("R8 start after joint grant", start, 1);
      chk("R9 xor result", res, 16'hff00);
      step(1'b0, 2'd0, 2'b00, 1'b0, 16'h0, 16'h0);

      // Constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         logic iss;
         iss = (m_req == '0) && (m_req_prev == '0) && ($urandom_range(1) == 1);
         step(iss, OW'($urandom_range(3)),
              {($urandom_range(9) < 4), ($urandom_range(9) < 4)},
              ($urandom_range(15) == 0), 16'($urandom), 16'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule